// File: doc/BRIEF.md
# Receive DMA Process Controller

This block is the control core for the receive side of a descriptor-driven Ethernet MAC. It keeps a process state (stopped, running or suspended) that moves on four host commands: start, stop, reset and poll demand. While running, it works through a fixed per-frame loop. It requests a descriptor. If the hardware owns that descriptor, it waits for the datapath to recognize a frame. It then lets MII data into the local receive buffer until the frame ends. Next it asks a transfer agent to copy the buffer to shared memory. Last, it writes the descriptor back with its ownership bit cleared, which returns the descriptor to the host.

A descriptor still owned by the host parks the process in suspended and raises a one-cycle buffer-unavailable pulse for the interrupt logic. Either a poll demand or a newly recognized frame resumes the process, and it restarts with a descriptor fetch. A stop that arrives while a frame is being stored, copied or closed waits until that descriptor has been handed back. All commands and handshake inputs are single-cycle qualifiers sampled on the rising clock edge. The requests are level outputs that stay high until their acknowledge arrives.

Top module: `rx_dma_ctrl`

## Requirements
- R1: After rst_ni the status is 2'b00 (stopped) with every request low. The status encoding is 2'b00 stopped, 2'b01 running, 2'b10 suspended, and 2'b11 never appears.
- R2: A start command seen while stopped gives status 2'b01 and desc_req_o high in the next cycle. Start is ignored while running or suspended, and also when stop arrives in the same cycle.
- R3: A descriptor acknowledge with desc_own_i=1 (hardware owns it) moves the loop to waiting. mii_en_o rises only after frame_seen_i and stays high until frame_end_i. A frame_seen_i during the fetch is ignored.
- R4: A reset command forces status 2'b00 and drops all requests in the next cycle, from any state, and it outranks every other input.
- R5: A descriptor acknowledge with desc_own_i=0 while running gives status 2'b10 with all requests low in the next cycle.
- R6: rbu_o is high for exactly the first cycle in which the status reads suspended.
- R7: After frame_end_i, xfer_req_o holds until xfer_done_i. Then wb_req_o (write-back with ownership cleared) holds until wb_ack_i. Then desc_req_o rises for the next descriptor.
- R8: In suspended, either a poll demand or frame_seen_i gives status 2'b01 with desc_req_o high in the next cycle. Other inputs leave it suspended.
- R9: A stop command while fetching, while waiting for a frame, or while suspended gives status 2'b00 with all requests low in the next cycle.
- R10: A stop command while storing, copying or writing back leaves the frame running. The process stops in the cycle after wb_ack_i, and no new fetch is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | Host start-receive command |
| cmd_stop_i | input | 1 | Host stop-receive command |
| cmd_reset_i | input | 1 | Host reset command |
| cmd_poll_i | input | 1 | Host poll demand |
| frame_seen_i | input | 1 | Datapath recognized an incoming frame |
| frame_end_i | input | 1 | Current frame fully stored in the receive buffer |
| desc_req_o | output | 1 | Request a descriptor fetch |
| desc_ack_i | input | 1 | Descriptor fetched; desc_own_i valid |
| desc_own_i | input | 1 | Ownership bit of fetched descriptor, 1 = hardware |
| mii_en_o | output | 1 | Accept MII data into the receive buffer |
| xfer_req_o | output | 1 | Request copy of buffer to shared memory |
| xfer_done_i | input | 1 | Copy to shared memory finished |
| wb_req_o | output | 1 | Request descriptor write-back with ownership cleared |
| wb_ack_i | input | 1 | Descriptor write-back finished |
| status_o | output | 2 | Process state code |
| rbu_o | output | 1 | One-cycle receive-buffer-unavailable event |

## Verification
Assertions check, on every cycle, that a reset command always lands in stopped, that a host-owned descriptor or a stop in suspended takes effect one cycle later, that the unavailable pulse lasts one cycle and marks every entry into suspended, and that the copy and write-back requests rise only after the step before them has completed. Only the bench's scenarios can show that the whole command-by-phase matrix, including ignored commands, lands in the right state with the right request. The same holds for a deferred stop finally landing after the write-back, and for a completed frame looping into the next descriptor fetch.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam int STAT_W = 2;
  localparam int PH_W   = 3;

  typedef enum logic [STAT_W-1:0] {
    PS_STOP = 2'b00,
    PS_RUN  = 2'b01,
    PS_SUSP = 2'b10
  } proc_st_t;

  typedef enum logic [PH_W-1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_WAIT,
    PH_STORE,
    PH_COPY,
    PH_CLOSE
  } phase_t;
endpackage

// File: rtl/rx_work_seq.sv
module rx_work_seq
  import rx_dma_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  input  logic abort_i,
  input  logic desc_ack_i,
  input  logic desc_own_i,
  input  logic frame_seen_i,
  input  logic frame_end_i,
  input  logic xfer_done_i,
  input  logic wb_ack_i,
  output logic desc_req_o,
  output logic mii_en_o,
  output logic xfer_req_o,
  output logic wb_req_o,
  output logic no_desc_o,
  output logic close_o,
  output logic in_frame_o
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FETCH: if (desc_ack_i)   phase_d = desc_own_i ? PH_WAIT : PH_IDLE;
      PH_WAIT:  if (frame_seen_i) phase_d = PH_STORE;
      PH_STORE: if (frame_end_i)  phase_d = PH_COPY;
      PH_COPY:  if (xfer_done_i)  phase_d = PH_CLOSE;
      PH_CLOSE: if (wb_ack_i)     phase_d = PH_FETCH;
      default:  phase_d = phase_q;
    endcase
    if (launch_i) phase_d = PH_FETCH;
    if (abort_i)  phase_d = PH_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign desc_req_o = (phase_q == PH_FETCH);
  assign mii_en_o   = (phase_q == PH_STORE);
  assign xfer_req_o = (phase_q == PH_COPY);
  assign wb_req_o   = (phase_q == PH_CLOSE);
  assign no_desc_o  = desc_req_o & desc_ack_i & ~desc_own_i;
  assign close_o    = wb_req_o & wb_ack_i;
  assign in_frame_o = mii_en_o | xfer_req_o | wb_req_o;

  AST_COPY_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_req_o) |-> $past(mii_en_o && frame_end_i)); // R7
  AST_CLOSE_AFTER_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_req_o) |-> $past(xfer_req_o && xfer_done_i)); // R7
  AST_STORE_AFTER_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mii_en_o) |-> $past(frame_seen_i)); // R3
endmodule

// File: rtl/rx_proc_fsm.sv
module rx_proc_fsm
  import rx_dma_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cmd_start_i,
  input  logic     cmd_stop_i,
  input  logic     cmd_reset_i,
  input  logic     cmd_poll_i,
  input  logic     frame_seen_i,
  input  logic     no_desc_i,
  input  logic     close_i,
  input  logic     in_frame_i,
  output proc_st_t state_o,
  output logic     launch_o,
  output logic     abort_o,
  output logic     rbu_o
);
  proc_st_t st_q, st_d;
  logic     pend_q, pend_d;
  logic     rbu_q;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    launch_o = 1'b0;
    abort_o  = 1'b0;
    if (cmd_reset_i) begin
      st_d    = PS_STOP;
      pend_d  = 1'b0;
      abort_o = 1'b1;
    end else begin
      unique case (st_q)
        PS_STOP: if (cmd_start_i && !cmd_stop_i) begin
          st_d     = PS_RUN;
          launch_o = 1'b1;
        end
        PS_RUN: begin
          if (close_i && (cmd_stop_i || pend_q)) begin
            st_d    = PS_STOP;
            pend_d  = 1'b0;
            abort_o = 1'b1;
          end else if (cmd_stop_i && !in_frame_i) begin
            st_d    = PS_STOP;
            abort_o = 1'b1;
          end else if (cmd_stop_i) begin
            pend_d  = 1'b1;  // defer until descriptor closes
          end else if (no_desc_i) begin
            st_d    = PS_SUSP;
          end
        end
        PS_SUSP: begin
          if (cmd_stop_i) begin
            st_d    = PS_STOP;
            abort_o = 1'b1;
          end else if (cmd_poll_i || frame_seen_i) begin
            st_d     = PS_RUN;
            launch_o = 1'b1;
          end
        end
        default: st_d = PS_STOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_STOP;
      pend_q <= 1'b0;
      rbu_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      rbu_q  <= (st_q != PS_SUSP) && (st_d == PS_SUSP);
    end
  end

  assign state_o = st_q;
  assign rbu_o   = rbu_q;

  AST_RESET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_reset_i |=> st_q == PS_STOP); // R4
  AST_RBU_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbu_q |=> !rbu_q); // R6
  AST_SUSP_ENTRY_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_SUSP && $past(st_q) != PS_SUSP) |-> rbu_q); // R6
  AST_RUN_NEEDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_RUN && $past(st_q) == PS_STOP) |-> $past(cmd_start_i)); // R2
  AST_SUSP_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_SUSP && cmd_stop_i && !cmd_reset_i) |=> st_q == PS_STOP); // R9
endmodule

// File: rtl/rx_dma_ctrl.sv
module rx_dma_ctrl
  import rx_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic              cmd_stop_i,
  input  logic              cmd_reset_i,
  input  logic              cmd_poll_i,
  input  logic              frame_seen_i,
  input  logic              frame_end_i,
  output logic              desc_req_o,
  input  logic              desc_ack_i,
  input  logic              desc_own_i,
  output logic              mii_en_o,
  output logic              xfer_req_o,
  input  logic              xfer_done_i,
  output logic              wb_req_o,
  input  logic              wb_ack_i,
  output logic [STAT_W-1:0] status_o,
  output logic              rbu_o
);
  proc_st_t st;
  logic     launch, abort, no_desc, close_evt, in_frame;

  rx_proc_fsm u_proc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_start_i (cmd_start_i),
    .cmd_stop_i  (cmd_stop_i),
    .cmd_reset_i (cmd_reset_i),
    .cmd_poll_i  (cmd_poll_i),
    .frame_seen_i(frame_seen_i),
    .no_desc_i   (no_desc),
    .close_i     (close_evt),
    .in_frame_i  (in_frame),
    .state_o     (st),
    .launch_o    (launch),
    .abort_o     (abort),
    .rbu_o       (rbu_o)
  );

  rx_work_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .abort_i     (abort),
    .desc_ack_i  (desc_ack_i),
    .desc_own_i  (desc_own_i),
    .frame_seen_i(frame_seen_i),
    .frame_end_i (frame_end_i),
    .xfer_done_i (xfer_done_i),
    .wb_ack_i    (wb_ack_i),
    .desc_req_o  (desc_req_o),
    .mii_en_o    (mii_en_o),
    .xfer_req_o  (xfer_req_o),
    .wb_req_o    (wb_req_o),
    .no_desc_o   (no_desc),
    .close_o     (close_evt),
    .in_frame_o  (in_frame)
  );

  assign status_o = st;

  AST_NODESC_SUSPENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && desc_ack_i && !desc_own_i && !cmd_reset_i && !cmd_stop_i)
      |=> status_o == PS_SUSP); // R5
  AST_STOP_DEFERRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_req_o && cmd_stop_i && !cmd_reset_i) |=> status_o == PS_RUN); // R10
  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != PS_RUN) |-> !(desc_req_o || mii_en_o || xfer_req_o || wb_req_o)); // R9
endmodule

// File: tb/sim_rx_dma_ctrl.sv
`timescale 1ns/1ps
module sim_rx_dma_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic c_start, c_stop, c_reset, c_poll;
  logic frame_seen, frame_end, desc_ack, desc_own, xfer_done, wb_ack;
  logic desc_req, mii_en, xfer_req, wb_req, rbu;
  logic [1:0] status;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_dma_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_start_i(c_start), .cmd_stop_i(c_stop), .cmd_reset_i(c_reset), .cmd_poll_i(c_poll),
    .frame_seen_i(frame_seen), .frame_end_i(frame_end),
    .desc_req_o(desc_req), .desc_ack_i(desc_ack), .desc_own_i(desc_own),
    .mii_en_o(mii_en), .xfer_req_o(xfer_req), .xfer_done_i(xfer_done),
    .wb_req_o(wb_req), .wb_ack_i(wb_ack), .status_o(status), .rbu_o(rbu)
  );

  // phases: 0 stop, 1 fetch, 2 wait, 3 store, 4 copy, 5 close, 6 suspended
  function automatic logic [5:0] exp_vec(int p);
    logic [1:0] s;
    logic [3:0] r;
    s = (p == 0) ? 2'b00 : (p == 6) ? 2'b10 : 2'b01;
    r = (p == 1) ? 4'b1000 : (p == 3) ? 4'b0100 : (p == 4) ? 4'b0010 :
        (p == 5) ? 4'b0001 : 4'b0000;
    return {s, r};
  endfunction

  // cmd: 0 none, 1 start, 2 stop, 3 reset, 4 poll
  function automatic int exp_next(int p, int c);
    if (c == 3) return 0;
    if (p == 0) return (c == 1) ? 1 : 0;
    if (p == 6) return (c == 2) ? 0 : (c == 4) ? 1 : 6;
    if (c == 2 && p <= 2) return 0;
    return p;
  endfunction

  function automatic logic [5:0] obs();
    return {status, desc_req, mii_en, xfer_req, wb_req};
  endfunction

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clr();
    c_start = 0; c_stop = 0; c_reset = 0; c_poll = 0;
    frame_seen = 0; frame_end = 0; desc_ack = 0; desc_own = 0;
    xfer_done = 0; wb_ack = 0;
  endtask

  task automatic hard_reset();
    clr();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic goto(int p);
    hard_reset();
    if (p == 0) return;
    c_start = 1; @(negedge clk); clr();
    if (p == 1) return;
    desc_ack = 1; desc_own = (p != 6); @(negedge clk); clr();
    if (p == 6 || p == 2) return;
    frame_seen = 1; @(negedge clk); clr();
    if (p == 3) return;
    frame_end = 1; @(negedge clk); clr();
    if (p == 4) return;
    xfer_done = 1; @(negedge clk); clr();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    string tag;
    clr();
    hard_reset();
    chk("R1 reset state", obs(), 6'b00_0000);
    chk("R1 rbu after reset", {5'b0, rbu}, 6'b0);

    // command x phase sweep
    for (int p = 0; p < 7; p++) begin
      for (int c = 0; c < 5; c++) begin
        goto(p);
        c_start = (c == 1); c_stop = (c == 2); c_reset = (c == 3); c_poll = (c == 4);
        @(negedge clk); clr();
        if (c == 3) tag = "R4";
        else if (c == 2 && p >= 3 && p <= 5) tag = "R10";
        else if (c == 2) tag = "R9";
        else if (p == 6) tag = "R8";
        else if (p == 0 || c == 1) tag = "R2";
        else tag = "R1";
        chk($sformatf("%s phase=%0d cmd=%0d", tag, p, c), obs(), exp_vec(exp_next(p, c)));
      end
    end

    // R5 / R6: host-owned descriptor suspends, pulse lasts one cycle
    goto(1);
    desc_ack = 1; desc_own = 0; @(negedge clk); clr();
    chk("R5 suspend on host-owned desc", obs(), exp_vec(6));
    chk("R6 rbu raised on entry", {5'b0, rbu}, 6'b1);
    @(negedge clk);
    chk("R6 rbu single cycle", {5'b0, rbu}, 6'b0);

    // R3: frame_seen during fetch ignored; capture holds until frame_end
    goto(1);
    frame_seen = 1; @(negedge clk); clr();
    chk("R3 frame_seen in fetch ignored", obs(), exp_vec(1));
    goto(3);
    repeat (3) @(negedge clk);
    chk("R3 capture held", obs(), exp_vec(3));

    // R7: full frame loops to next fetch
    goto(5);
    repeat (2) @(negedge clk);
    chk("R7 write-back held", obs(), exp_vec(5));
    wb_ack = 1; @(negedge clk); clr();
    chk("R7 next descriptor fetch", obs(), exp_vec(1));

    // R10: stop during copy lands after write-back
    goto(4);
    c_stop = 1; @(negedge clk); clr();
    xfer_done = 1; @(negedge clk); clr();
    chk("R10 still closing", obs(), exp_vec(5));
    wb_ack = 1; @(negedge clk); clr();
    chk("R10 stopped after close", obs(), exp_vec(0));
    @(negedge clk);
    chk("R10 no new fetch", obs(), exp_vec(0));

    // R8: frame recognized resumes from suspended
    goto(6);
    frame_seen = 1; @(negedge clk); clr();
    chk("R8 frame resumes", obs(), exp_vec(1));

    // R2: start with stop in same cycle stays stopped
    goto(0);
    c_start = 1; c_stop = 1; @(negedge clk); clr();
    chk("R2 start+stop stays stopped", obs(), exp_vec(0));

    // R4: reset beats no-desc event
    goto(1);
    c_reset = 1; desc_ack = 1; desc_own = 0; @(negedge clk); clr();
    chk("R4 reset beats suspend", obs(), exp_vec(0));
    chk("R4 no rbu on reset", {5'b0, rbu}, 6'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule